// File: doc/BRIEF.md
# Rotate-Right Insert-Bit Execution Slice

This block is a small fixed-point execution slice that recognises and executes a single instruction. The instruction copies the sign bit (the most significant bit) of a 32-bit source operand into one bit of the old destination value. The position of that bit is a 5-bit rotate amount taken from a count operand. Every other destination bit keeps its old value. The instruction has a record form, which also produces a 4-bit condition field from the new result.

The surrounding pipeline reads the three operands from its register file and presents them with the instruction word, a valid strobe and the current summary-overflow flag. One clock later the slice returns three things:
- a decode-hit flag;
- the new destination value with its register write enable;
- when the record form was issued, the condition field with its own write enable.

The fixed-point exception state (overflow and carry) has no port here, because the instruction never changes it.

Bits of the instruction and of operands are numbered big-endian: bit 0 is the most significant bit, which is index [31] of a SystemVerilog vector.

Top module: `bitrot_insert_unit`

## Requirements
- R1: The instruction is decoded when `in_valid` is high, `insn[31:26]` (big-endian bits 0-5) equals 31 and `insn[10:1]` (big-endian bits 21-30) equals 537. The record flag is `insn[0]` (big-endian bit 31).
- R2: The rotate amount n is `cnt_val[4:0]` (range 0 to 31). All higher count bits are ignored.
- R3: The result bit at big-endian position n, which is vector index 31-n, equals `src_val[31]`.
- R4: Every other bit of the result equals the corresponding bit of `dst_old`. For example, source 0x00000000 with n=4 and old value 0xFFFFFFFF gives 0xF7FFFFFF, and source 0xB0043000 with n=4 and old value 0 gives 0x08000000.
- R5: On a decoded record-form instruction, `cr_we` is high and `cr_out` holds {LT, GT, EQ, SO} in bits [3], [2], [1] and [0].
- R6: On a decoded instruction whose record flag is 0, `cr_we` stays low.
- R7: LT, GT and EQ come from a signed comparison of the 32-bit result with zero, and exactly one of the three is set.
- R8: SO equals the `so_in` value presented with the instruction.
- R9: `hit`, `rf_we`, `res` and `cr_out` appear exactly one clock after the instruction is presented.
- R10: If the opcode fields do not match, `hit`, `rf_we` and `cr_we` are all low in the next cycle.
- R11: A synchronous active-high `rst` clears `hit`, `rf_we` and `cr_we`.
- R12: When `in_valid` is low, `hit`, `rf_we` and `cr_we` are all low in the next cycle, whatever the instruction word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are valid |
| insn | input | 32 | Instruction word |
| src_val | input | 32 | Source operand value |
| cnt_val | input | 32 | Count operand value |
| dst_old | input | 32 | Current destination value |
| so_in | input | 1 | Current summary-overflow flag |
| hit | output | 1 | Decode hit, registered |
| rf_we | output | 1 | Destination register write enable |
| res | output | 32 | New destination value |
| cr_we | output | 1 | Condition field write enable |
| cr_out | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Two functions can land in the same cycle: the single-bit insertion and the condition-field update, which must judge the sign and zero state of the value just produced rather than of the old destination. The bench provokes the case where they interact. It uses record-form instructions with n=0, so that the inserted bit is the sign bit itself, and others where the insertion turns a zero destination nonzero or clears its only set bit. A behavioural model computes the result bit by bit and classifies it with signed integer arithmetic. That model is compared with every output field on every clock, including cycles where the opcode misses, where the instruction is not valid and where a reset lands in the middle of the stream.

// File: rtl/bitrot_insert_unit.sv
module bitrot_insert_unit #(
  parameter int XLEN   = 32,
  parameter int PRI_OP = 31,
  parameter int EXT_OP = 537
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] cnt_val,
  input  logic [XLEN-1:0] dst_old,
  input  logic            so_in,
  output logic            hit,
  output logic            rf_we,
  output logic [XLEN-1:0] res,
  output logic            cr_we,
  output logic [3:0]      cr_out
);
  localparam int SHW = $clog2(XLEN);

  logic            dec_ok;
  logic            rec;
  logic [SHW-1:0]  amt;
  logic [SHW-1:0]  pos;
  logic [XLEN-1:0] nxt;
  logic            f_lt, f_gt, f_eq;

  assign dec_ok = in_valid && (insn[31:26] == PRI_OP[5:0]) && (insn[10:1] == EXT_OP[9:0]);
  assign rec    = insn[0];
  assign amt    = cnt_val[SHW-1:0];
  assign pos    = SHW'(XLEN-1) - amt;

  always_comb begin
    nxt      = dst_old;
    nxt[pos] = src_val[XLEN-1];
  end

  assign f_lt = nxt[XLEN-1];
  assign f_eq = (nxt == '0);
  assign f_gt = !f_lt && !f_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit    <= 1'b0;
      rf_we  <= 1'b0;
      cr_we  <= 1'b0;
      res    <= '0;
      cr_out <= '0;
    end else begin
      hit   <= dec_ok;
      rf_we <= dec_ok;
      cr_we <= dec_ok && rec;
      if (dec_ok) begin
        res    <= nxt;
        cr_out <= {f_lt, f_gt, f_eq, so_in};
      end
    end
  end

  a_r4_single_bit_change: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($countones(res ^ $past(dst_old)) <= 1));
  a_r3_bit_from_source: assert property (@(posedge clk) disable iff (rst)
    hit |-> (res[SHW'(XLEN-1) - $past(cnt_val[SHW-1:0])] == $past(src_val[XLEN-1])));
  a_r6_cr_needs_hit: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (hit && rf_we));
  a_r7_one_relation: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> ($countones(cr_out[3:1]) == 1));
  a_r7_sign_agrees: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (cr_out[3] == res[XLEN-1]) && (cr_out[1] == (res == '0)));
  a_r8_so_copied: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (cr_out[0] == $past(so_in)));
  a_r10_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (!rf_we && !cr_we));
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !hit);
endmodule

// File: tb/sim_bitrot_insert_unit.sv
module sim_bitrot_insert_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0, src_val = '0, cnt_val = '0, dst_old = '0;
  logic so_in = 1'b0;
  logic hit, rf_we, cr_we;
  logic [31:0] res;
  logic [3:0] cr_out;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  logic        e_hit = 0, e_rfwe = 0, e_crwe = 0;
  logic [31:0] e_res = 0;
  logic [3:0]  e_cr = 0;

  always #4 clk = ~clk;

  bitrot_insert_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_val(src_val), .cnt_val(cnt_val), .dst_old(dst_old), .so_in(so_in),
    .hit(hit), .rf_we(rf_we), .res(res), .cr_we(cr_we), .cr_out(cr_out)
  );

  function automatic logic [31:0] mk(input int pri, input int xo, input bit rc);
    logic [31:0] w;
    w = $urandom;
    w[31:26] = pri[5:0];
    w[10:1] = xo[9:0];
    w[0] = rc;
    return w;
  endfunction

  task automatic chk1(input string tag, input logic a, input logic e);
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, a, e);
    end
  endtask

  task automatic compare();
    vectors++;
    chk1("R1/R9/R10/R12 hit", hit, e_hit);
    chk1("R10/R11 rf_we", rf_we, e_rfwe);
    chk1("R5/R6 cr_we", cr_we, e_crwe);
    if (e_hit && res !== e_res) begin
      errors++;
      $display("FAIL R2/R3/R4 res: got %h expected %h", res, e_res);
    end
    if (e_crwe && cr_out !== e_cr) begin
      errors++;
      $display("FAIL R7/R8 cr_out: got %b expected %b", cr_out, e_cr);
    end
  endtask

  // Behavioural model: outputs expected one clock after presentation (R9).
  task automatic step(input bit r, input bit v, input logic [31:0] w,
                      input logic [31:0] s, input logic [31:0] c,
                      input logic [31:0] d, input bit so);
    int n;
    int sv;
    logic [31:0] t;
    rst = r; in_valid = v; insn = w; src_val = s; cnt_val = c; dst_old = d; so_in = so;
    n = c % 32;
    t = 0;
    for (int i = 0; i < 32; i++) begin
      if ((31 - i) == n) t[i] = s[31];
      else t[i] = d[i];
    end
    if (r) begin
      e_hit = 0; e_rfwe = 0; e_crwe = 0;
    end else begin
      e_hit = v && (w[31:26] == 6'd31) && (w[10:1] == 10'd537);
      e_rfwe = e_hit;
      e_crwe = e_hit && w[0];
      if (e_hit) begin
        e_res = t;
        sv = t;
        e_cr = {sv < 0, sv > 0, sv == 0, so};
      end
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 0);
    // R11 reset state
    step(1, 1, mk(31, 537, 1), 32'h8000_0000, 0, 0, 1);
    // R4 examples, R6 non-record
    step(0, 1, mk(31, 537, 0), 32'h0000_0000, 32'd4, 32'hFFFF_FFFF, 0);
    step(0, 1, mk(31, 537, 1), 32'hB004_3000, 32'd4, 32'h0000_0000, 1);
    // R2 upper count bits ignored
    step(0, 1, mk(31, 537, 1), 32'h8000_0000, 32'hFFFF_FFE3, 32'h0, 0);
    // R3 n=0 sets sign, R7 LT; n=31 to bit 0
    step(0, 1, mk(31, 537, 1), 32'h8000_0000, 32'd0, 32'h0000_0001, 0);
    step(0, 1, mk(31, 537, 1), 32'h7FFF_FFFF, 32'd0, 32'hFFFF_FFFF, 1);
    step(0, 1, mk(31, 537, 1), 32'h8000_0000, 32'd31, 32'h0, 1);
    // R7 EQ after clearing the only set bit; R8 so copy
    step(0, 1, mk(31, 537, 1), 32'h0, 32'd31, 32'h1, 1);
    step(0, 1, mk(31, 537, 1), 32'h0, 32'd12, 32'h0008_0000, 0);
    // R10 opcode misses
    step(0, 1, mk(30, 537, 1), 32'h8000_0000, 32'd3, 32'h0, 1);
    step(0, 1, mk(31, 536, 1), 32'h8000_0000, 32'd3, 32'h0, 1);
    step(0, 1, mk(63, 537, 1), 32'h8000_0000, 32'd3, 32'h0, 1);
    // R12 not valid
    step(0, 0, mk(31, 537, 1), 32'h8000_0000, 32'd3, 32'h0, 1);
    // back-to-back then mid-stream reset (R11)
    step(0, 1, mk(31, 537, 1), 32'h8000_0000, 32'd5, 32'h0, 0);
    step(1, 1, mk(31, 537, 1), 32'h8000_0000, 32'd6, 32'h0, 0);
    step(0, 1, mk(31, 537, 1), 32'h8000_0000, 32'd7, 32'h0, 1);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      int sel;
      sel = $urandom % 8;
      w = mk((sel == 0) ? 30 : 31, (sel == 1) ? 538 : 537, $urandom % 2);
      step(($urandom % 50) == 0, ($urandom % 6) != 0, w,
           $urandom, $urandom, (sel == 2) ? 32'h0 : $urandom, $urandom % 2);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule